// File: doc/BRIEF.md
# Masked Multi-Signal Condition Trigger

This block watches a small group of single-bit inputs and reports when each of them has shown a chosen behaviour since monitoring was armed. A rising edge on `enable` arms a new window. At that moment, the block captures a per-input select bit and a per-input 2-bit condition code. After that, it evaluates every selected input on each clock. A condition can be a level (high or low) or a transition (rising or falling).

Each input has its own sticky satisfied flag. The single `ready` output rises once every selected input has met its condition, even if the inputs met them on different cycles. Inputs that are not selected count as satisfied from the start of the window. The flags and `ready` hold until the next arming edge or a reset. The inputs are assumed to be synchronous to `clk` already.

Top module: `cond_trigger_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sat` and `ready` are cleared. They stay 0 until `enable` is next seen rising, whatever the watched inputs do.
- R2: Condition code 2'b00 (field `code[2i+1:2i]` belongs to input i) sets `sat[i]` at the first clock edge after arming at which `sig[i]` is sampled high.
- R3: Code 2'b01 sets `sat[i]` at the first edge after arming at which `sig[i]` is sampled low.
- R4: Code 2'b10 sets `sat[i]` at an edge where `sig[i]` is 1 and was 0 at the previous edge. A level that was already 1 at the arming edge is not a rising edge.
- R5: Code 2'b11 sets `sat[i]` at an edge where `sig[i]` is 0 and was 1 at the previous edge. A level that was already 0 at the arming edge is not a falling edge.
- R6: At the arming edge, `sat[i]` takes the inverse of `mask[i]`. A 0 bit means the input is not watched and counts as satisfied at once, so with all bits 0, `ready` is 1 right after arming.
- R7: From the arming edge on, `ready` is 1 exactly when every `sat` bit is 1. It rises at the same edge as the last flag to be set.
- R8: Set `sat` bits and `ready` stay set until the next arming edge. A falling `enable` or inputs returning to other values do not clear them.
- R9: An arming edge is a clock edge with `enable` at 1 where it was 0 at the previous edge. It clears every watched flag and starts a new window. The `mask` and `code` values sampled at that edge govern the whole window, and later changes to them have no effect until the next arming edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | A rising edge arms a monitoring window |
| sig | input | NUM_SIG | Watched inputs, already synchronous |
| mask | input | NUM_SIG | 1 = watch this input, 0 = treat as satisfied; sampled at arming |
| code | input | 2*NUM_SIG | Per-input condition code, input i at bits 2i+1:2i; sampled at arming |
| ready | output | 1 | All watched inputs have met their conditions |
| sat | output | NUM_SIG | Per-input sticky satisfied flags |

## Verification
The hardest situation to reach is an edge condition whose level is already present when the window is armed. The stimulus must hold that level through the arming edge, keep it for several cycles, and only then move the input the other way and back. This shows that the previous-sample register was reloaded at arming, and that no phantom edge was counted.

A second awkward case is a change to `mask`, `code` and `enable` inside an open window. Directed sequences first hold each input steady and then change the configuration. A long random phase follows, with rare re-arming. A cycle-by-cycle behavioural model in the bench judges both the directed and the random phases.

// File: rtl/cond_trig_pkg.sv
// Package: shared condition encoding and the per-cycle hit function.
// Assumes the current and previous samples are synchronous to the block clock.
package cond_trig_pkg;

    localparam int COND_W = 2;

    typedef enum logic [COND_W-1:0] {
        COND_HIGH = 2'b00,
        COND_LOW  = 2'b01,
        COND_RISE = 2'b10,
        COND_FALL = 2'b11
    } cond_e;

    // Decide whether one sample pair meets the selected condition.
    function automatic logic cond_hit(cond_e c, logic cur, logic prv);
        case (c)
            COND_HIGH: return cur;
            COND_LOW:  return !cur;
            COND_RISE: return cur && !prv;
            COND_FALL: return !cur && prv;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cond_arm.sv
// Module: cond_arm
// Detects the arming edge of enable and holds the mask and code captured
// there for the rest of the window. Assumes enable is synchronous to clk.
module cond_arm #(
    parameter int NUM_SIG = 4,
    parameter int CODE_BITS = NUM_SIG * cond_trig_pkg::COND_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [NUM_SIG-1:0]   mask_in,
    input  logic [CODE_BITS-1:0] code_in,
    output logic                 start,
    output logic                 active,
    output logic [NUM_SIG-1:0]   mask_held,
    output logic [CODE_BITS-1:0] code_held
);

    logic en_q;

    // Arming edge: enable high now, low at the previous edge.
    always_comb start = enable && !en_q;

    // Track enable and keep the window open once armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            active <= 1'b0;
        end else begin
            en_q <= enable;
            if (start) active <= 1'b1;
        end
    end

    // Capture the configuration at the arming edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_held <= '0;
            code_held <= '0;
        end else if (start) begin
            mask_held <= mask_in;
            code_held <= code_in;
        end
    end

endmodule

// File: rtl/cond_chan.sv
// Module: cond_chan
// One watched input: keeps the previous sample for edge detection and a
// sticky satisfied flag. Assumes start and active come from cond_arm.
module cond_chan
    import cond_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic              mask_live,
    input  logic              mask_held,
    input  logic [COND_W-1:0] code_held,
    input  logic              sig,
    output logic              sat
);

    logic prev;
    logic hit;

    // Evaluate the held condition against the current and previous samples.
    always_comb hit = mask_held && cond_hit(cond_e'(code_held), sig, prev);

    // Previous sample; reloaded every cycle, including the arming edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sig;
    end

    // Sticky flag: seeded from the mask at arming, set on a hit afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)              sat <= 1'b0;
        else if (start)          sat <= !mask_live;
        else if (active && hit)  sat <= 1'b1;
    end

endmodule

// File: rtl/cond_ready.sv
// Module: cond_ready
// Combines the per-input flags into the ready output. Assumes flags are
// cleared by reset and re-seeded at every arming edge.
module cond_ready #(
    parameter int NUM_SIG = 4
) (
    input  logic               active,
    input  logic [NUM_SIG-1:0] sat,
    output logic               ready
);

    // Ready only inside a window and only when no flag is still missing.
    always_comb ready = active && (&sat);

endmodule

// File: rtl/cond_trigger_top.sv
// Module: cond_trigger_top
// Watches NUM_SIG inputs for per-input level or edge conditions after an
// arming edge on enable; raises ready once all watched inputs are satisfied.
// Assumes all inputs are synchronous to clk.
module cond_trigger_top #(
    parameter int NUM_SIG = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  enable,
    input  logic [NUM_SIG-1:0]                    sig,
    input  logic [NUM_SIG-1:0]                    mask,
    input  logic [NUM_SIG*cond_trig_pkg::COND_W-1:0] code,
    output logic                                  ready,
    output logic [NUM_SIG-1:0]                    sat
);

    localparam int CW        = cond_trig_pkg::COND_W;
    localparam int CODE_BITS = NUM_SIG * CW;

    logic                 start;
    logic                 active;
    logic [NUM_SIG-1:0]   mask_held;
    logic [CODE_BITS-1:0] code_held;

    cond_arm #(.NUM_SIG(NUM_SIG), .CODE_BITS(CODE_BITS)) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .mask_in   (mask),
        .code_in   (code),
        .start     (start),
        .active    (active),
        .mask_held (mask_held),
        .code_held (code_held)
    );

    // One channel per watched input.
    for (genvar i = 0; i < NUM_SIG; i++) begin : g_chan
        cond_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start),
            .active    (active),
            .mask_live (mask[i]),
            .mask_held (mask_held[i]),
            .code_held (code_held[i*CW +: CW]),
            .sig       (sig[i]),
            .sat       (sat[i])
        );
    end

    cond_ready #(.NUM_SIG(NUM_SIG)) u_ready (
        .active (active),
        .sat    (sat),
        .ready  (ready)
    );

endmodule

// File: rtl/cond_trig_chk.sv
// Module: cond_trig_chk
// Port-level properties for cond_trigger_top; bound to every instance.
// Keeps its own copy of the arming-edge detection.
module cond_trig_chk #(
    parameter int NUM_SIG = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic [NUM_SIG-1:0] mask,
    input logic               ready,
    input logic [NUM_SIG-1:0] sat
);

    logic en_seen;
    logic armed;
    logic arm_edge;

    // Independent arming-edge view for the properties.
    always_comb arm_edge = enable && !en_seen;

    // Remember enable and whether any window has been armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_seen <= 1'b0;
            armed   <= 1'b0;
        end else begin
            en_seen <= enable;
            if (arm_edge) armed <= 1'b1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (sat == '0 && !ready));

    // R6
    seed_from_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_edge |=> (sat == ~$past(mask)));

    // R7
    ready_low_at_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_edge && (|mask)) |=> !ready);

    // R7
    ready_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (&sat));

    // R8
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_edge |=> ((sat & $past(sat)) == $past(sat)));

    // R8
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !arm_edge) |=> ready);

endmodule

bind cond_trigger_top cond_trig_chk #(.NUM_SIG(NUM_SIG)) u_cond_trig_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .mask   (mask),
    .ready  (ready),
    .sat    (sat)
);

// File: tb/tb_cond_trigger_top.sv
// Bench for cond_trigger_top: directed windows plus a random phase, judged
// against a behavioural model updated every clock.
module tb_cond_trigger_top;

    localparam int N = 4;
    localparam time CLK_HALF = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [N-1:0] sig = '0;
    logic [N-1:0] mask = '0;
    logic [2*N-1:0] code = '0;
    logic         ready;
    logic [N-1:0] sat;

    int checks = 0;
    int failures = 0;

    cond_trigger_top #(.NUM_SIG(N)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sig(sig),
        .mask(mask), .code(code), .ready(ready), .sat(sat)
    );

    always #(CLK_HALF) clk = ~clk;

    // Behavioural reference state
    bit m_en_prev, m_active, m_valid;
    bit m_mask[N];
    int m_code[N];
    bit m_prev[N];
    bit m_sat[N];

    function automatic logic [N:0] model_out();
        logic [N:0] v;
        bit all = 1;
        for (int i = 0; i < N; i++) begin
            v[i] = m_sat[i];
            if (!m_sat[i]) all = 0;
        end
        v[N] = m_active && all;
        return v;
    endfunction

    always @(posedge clk) begin
        m_valid = 1;
        if (!rst_n) begin
            m_en_prev = 0; m_active = 0;
            for (int i = 0; i < N; i++) begin
                m_mask[i] = 0; m_code[i] = 0; m_prev[i] = 0; m_sat[i] = 0;
            end
        end else begin
            bit st;
            st = enable && !m_en_prev;
            m_en_prev = enable;
            for (int i = 0; i < N; i++) begin
                if (st) begin
                    m_mask[i] = mask[i];
                    m_code[i] = int'(code[2*i +: 2]);
                    m_sat[i]  = !mask[i];
                end else if (m_active && m_mask[i]) begin
                    bit h;
                    case (m_code[i])
                        0: h = sig[i];
                        1: h = !sig[i];
                        2: h = sig[i] && !m_prev[i];
                        default: h = !sig[i] && m_prev[i];
                    endcase
                    if (h) m_sat[i] = 1;
                end
                m_prev[i] = sig[i];
            end
            if (st) m_active = 1;
        end
    end

    task automatic check(string tag, logic [N:0] act, logic [N:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {ready,sat} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (m_valid) check("R2/R3/R4/R5/R7 model", {ready, sat}, model_out());
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic arm(logic [N-1:0] mk, logic [2*N-1:0] cd);
        enable = 1'b0;
        tick();
        mask = mk;
        code = cd;
        enable = 1'b1;
        tick();
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(); tick();
        // R1: reset state, then input activity without arming
        check("R1 reset", {ready, sat}, 5'b0);
        rst_n = 1'b1;
        sig = 4'b1111; tick();
        sig = 4'b0000; tick();
        check("R1 idle", {ready, sat}, 5'b0);

        // R2: high level on input 0
        sig = '0;
        arm(4'b0001, 8'b00000000);
        check("R2 armed", {ready, sat}, 5'b01110);
        tick();
        check("R2 wait", {ready, sat}, 5'b01110);
        sig[0] = 1'b1; tick();
        check("R2 hit", {ready, sat}, 5'b11111);

        // R3: low level on input 1, starting high
        sig = 4'b0010;
        arm(4'b0010, 8'b00000100);
        tick();
        check("R3 wait", {ready, sat}, 5'b01101);
        sig[1] = 1'b0; tick();
        check("R3 hit", {ready, sat}, 5'b11111);

        // R4: rising on input 2, already high at arming
        sig = 4'b0100;
        arm(4'b0100, 8'b00100000);
        tick(); tick(); tick();
        check("R4 no phantom edge", {ready, sat}, 5'b01011);
        sig[2] = 1'b0; tick();
        check("R4 falling ignored", {ready, sat}, 5'b01011);
        sig[2] = 1'b1; tick();
        check("R4 rise", {ready, sat}, 5'b11111);

        // R5: falling on input 3, already low at arming
        sig = 4'b0000;
        arm(4'b1000, 8'b11000000);
        tick(); tick();
        check("R5 no phantom edge", {ready, sat}, 5'b00111);
        sig[3] = 1'b1; tick();
        check("R5 rising ignored", {ready, sat}, 5'b00111);
        sig[3] = 1'b0; tick();
        check("R5 fall", {ready, sat}, 5'b11111);

        // R7: four conditions met on different cycles
        sig = 4'b1010;
        arm(4'b1111, 8'b11100100);
        check("R7 start", {ready, sat}, 5'b00000);
        sig[0] = 1'b1; tick();
        check("R7 first", {ready, sat}, 5'b00001);
        sig[1] = 1'b0; tick();
        check("R7 second", {ready, sat}, 5'b00011);
        sig[2] = 1'b1; tick();
        check("R7 third", {ready, sat}, 5'b00111);
        sig[3] = 1'b0; tick();
        check("R7 last", {ready, sat}, 5'b11111);

        // R6: partly and fully unwatched inputs
        sig = '0;
        arm(4'b0101, 8'b00000000);
        check("R6 partial", {ready, sat}, 5'b01010);
        sig = 4'b0101; tick();
        check("R6 partial done", {ready, sat}, 5'b11111);
        arm(4'b0000, 8'b00000000);
        check("R6 none watched", {ready, sat}, 5'b11111);

        // R9: mid-window config change has no effect
        sig = '0;
        arm(4'b0011, 8'b00000000);
        mask = 4'b0000; code = 8'b01010101;
        tick(); tick();
        check("R9 held config", {ready, sat}, 5'b01100);
        // R8: dropping enable does not clear or finish
        enable = 1'b0; tick();
        check("R8 enable low", {ready, sat}, 5'b01100);
        sig = 4'b0011; tick();
        check("R7 held done", {ready, sat}, 5'b11111);
        sig = '0; tick(); tick();
        check("R8 sticky", {ready, sat}, 5'b11111);
        // R9: new arming edge clears
        arm(4'b0001, 8'b00000000);
        check("R9 rearm clears", {ready, sat}, 5'b01110);

        // R1: reset mid-window
        rst_n = 1'b0; tick();
        check("R1 reset mid", {ready, sat}, 5'b00000);
        enable = 1'b0;
        rst_n = 1'b1; tick();
        sig = 4'b1111; tick();
        check("R1 post reset idle", {ready, sat}, 5'b00000);

        // Random phase judged by the model
        for (int c = 0; c < 4000; c++) begin
            sig = N'($urandom);
            if ($urandom_range(0, 15) == 0) enable = !enable;
            mask = N'($urandom);
            code = (2*N)'($urandom);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule